// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

The block holds two 16-bit down-counting interval timers, A and B, behind a small byte-wide register bus. Each timer keeps a reload latch that software writes but cannot read back, a live counter that software can read, and a control register. A running timer counts one of several sources: system clocks, rising edges on an external count pin, or, for timer B only, underflows of timer A. When a counter at zero receives a count, it reloads from its latch and the timer emits a one-cycle underflow pulse for a downstream interrupt controller. A one-shot mode stops the timer after its first underflow. Continuous mode keeps it running.

The register bus is plain control access with no back-pressure. A transfer is presented by holding `bus_sel` high for one clock, with `bus_we` giving the direction. Writes take effect on that clock edge. Read data is combinational from the address and the current state. There is no ready signal and no wait state, so every select is accepted in the cycle it appears. Offsets that are not decoded read as zero, and writes to them are dropped. The count pin is asynchronous. It passes through a two-flop synchroniser and a rising-edge detector before it is used.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both latches and both counters hold 0xFFFF, and both control registers read 0x00.
- R2: Writes at offset 0x4/0x5 set the low/high byte of latch A, and writes at 0x6/0x7 set latch B. Reads at 0x4–0x7 return the low/high byte of the live counter. Control A reads at 0xE and control B at 0xF. Every other offset reads 0x00.
- R3: Writing the high latch byte while the timer's start bit (control bit 0) is 0 loads the whole new latch into the counter on that edge. Writing the low byte while stopped leaves the counter unchanged.
- R4: Writing a control register with bit 4 set loads the counter from the latch. Bit 4 is never stored and always reads as 0.
- R5: Writing a control register with bit 0 clear loads the counter from the latch. Writing bit 0 set without bit 4 leaves the counter unchanged on that edge.
- R6: A running timer that receives a count decrements by one. A count at zero instead reloads the latch on the same edge, and the underflow output is high for the following cycle. With a clock source and latch L, underflows repeat every L+1 cycles.
- R7: Control bit 3 selects one-shot mode, in which an underflow clears the start bit. With bit 3 clear the timer keeps running.
- R8: Timer A control bit 5 selects the source: 0 counts every clock, 1 counts rising edges of the count pin after the two-flop synchroniser.
- R9: Timer B bits 6:5 = 10 counts timer A underflows. The count lands on the same edge as timer A's reload.
- R10: Timer B bits 6:5 = 11 counts timer A underflows only while the synchronised count pin is high.
- R11: Timer B bits 6:5 = 00 counts clocks, and 01 counts count-pin rising edges.
- R12: A stopped timer's counter holds its value until a control write or a high-latch write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| count_pin | input | 1 | Asynchronous external count input |
| tmr_a_uf | output | 1 | One-cycle timer A underflow pulse |
| tmr_b_uf | output | 1 | One-cycle timer B underflow pulse |

## Verification
The hardest case to reach is gated cascading. Timer B advances only when a timer A underflow coincides with a high synchronised pin level, and the pin takes three cycles to reach the counter. A directed sequence runs timer A with a short latch, holds the pin low long enough to show that B does not move, and then raises it. Random phases keep latches small so that underflows, one-shot stops and source switches collide often with register writes. Every cycle is compared against a cycle-level model kept in the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_A_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_A_HI = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_B_LO = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_B_HI = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_A_CTL = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_B_CTL = 4'hF;

  localparam int CTL_START = 0;
  localparam int CTL_ONESHOT = 3;
  localparam int CTL_FORCE = 4;
  localparam int CTL_SRC_LO = 5;
  localparam int CTL_SRC_HI = 6;

  typedef enum logic [1:0] {
    SRC_CLK        = 2'b00,
    SRC_PIN        = 2'b01,
    SRC_CASC       = 2'b10,
    SRC_CASC_GATED = 2'b11
  } bsrc_e;
endpackage

// File: rtl/cnt_sync.sv
module cnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level,
  output logic rise
);
  localparam int TOTAL = STAGES + 1;
  logic [TOTAL-1:0] chain_q;

  for (genvar i = 0; i < TOTAL; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= pin_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter bit IS_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_rise,
  input  logic              pin_level,
  input  logic              casc_evt,
  output logic [2*DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic              uf_now,
  output logic              uf_pulse
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] FORCE_MASK = ~(DATA_W'(1) << CTL_FORCE);

  logic [CNT_W-1:0] latch_q, latch_nx;
  logic running, tick;

  assign running = ctl_q[CTL_START];

  if (IS_B) begin : g_src_b
    bsrc_e sel;
    assign sel = bsrc_e'(ctl_q[CTL_SRC_HI:CTL_SRC_LO]);
    always_comb begin
      case (sel)
        SRC_CLK:        tick = 1'b1;
        SRC_PIN:        tick = pin_rise;
        SRC_CASC:       tick = casc_evt;
        default:        tick = casc_evt & pin_level;
      endcase
    end
  end else begin : g_src_a
    logic unused_inputs;
    assign unused_inputs = pin_level ^ casc_evt;
    assign tick = ctl_q[CTL_SRC_LO] ? pin_rise : 1'b1;
  end

  always_comb begin
    latch_nx = latch_q;
    if (wr_lo) latch_nx[DATA_W-1:0] = wdata;
    if (wr_hi) latch_nx[CNT_W-1:DATA_W] = wdata;
  end

  assign uf_now = running && tick && (cnt_q == '0) && !wr_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= ALL_ONES;
      cnt_q    <= ALL_ONES;
      ctl_q    <= '0;
      uf_pulse <= 1'b0;
    end else begin
      latch_q  <= latch_nx;
      uf_pulse <= uf_now;
      if (wr_ctl) begin
        ctl_q <= wdata & FORCE_MASK;
        if (wdata[CTL_FORCE] || !wdata[CTL_START]) cnt_q <= latch_nx;
      end else if (wr_hi && !running) begin
        cnt_q <= latch_nx;
      end else if (running && tick) begin
        if (cnt_q == '0) begin
          cnt_q <= latch_nx;
          if (ctl_q[CTL_ONESHOT]) ctl_q[CTL_START] <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  p_force_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && wdata[CTL_FORCE] |=> cnt_q == $past(latch_q) && !ctl_q[CTL_FORCE]);

  p_stop_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !wdata[CTL_START] |=> cnt_q == $past(latch_q) && !running);

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick && cnt_q != '0 && !wr_ctl |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_uf_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uf_now |=> cnt_q == $past(latch_nx) && uf_pulse);

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uf_now && ctl_q[CTL_ONESHOT] |=> !running);

  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi && !running && !wr_ctl |=> cnt_q == $past(latch_nx));

  p_stopped_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !wr_ctl && !wr_hi |=> $stable(cnt_q));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              count_pin,
  output logic              tmr_a_uf,
  output logic              tmr_b_uf
);
  localparam int CNT_W = 2 * DATA_W;

  logic wr;
  logic pin_level, pin_rise;
  logic a_uf_now, b_uf_now;
  logic [CNT_W-1:0] a_cnt, b_cnt;
  logic [DATA_W-1:0] a_ctl, b_ctl;

  assign wr = bus_sel && bus_we;

  cnt_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(count_pin),
    .level(pin_level), .rise(pin_rise)
  );

  timer_core #(.IS_B(1'b0)) u_tmr_a (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr && bus_addr == OFS_A_LO),
    .wr_hi(wr && bus_addr == OFS_A_HI),
    .wr_ctl(wr && bus_addr == OFS_A_CTL),
    .wdata(bus_wdata), .pin_rise(pin_rise), .pin_level(pin_level),
    .casc_evt(1'b0), .cnt_q(a_cnt), .ctl_q(a_ctl),
    .uf_now(a_uf_now), .uf_pulse(tmr_a_uf)
  );

  timer_core #(.IS_B(1'b1)) u_tmr_b (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr && bus_addr == OFS_B_LO),
    .wr_hi(wr && bus_addr == OFS_B_HI),
    .wr_ctl(wr && bus_addr == OFS_B_CTL),
    .wdata(bus_wdata), .pin_rise(pin_rise), .pin_level(pin_level),
    .casc_evt(a_uf_now), .cnt_q(b_cnt), .ctl_q(b_ctl),
    .uf_now(b_uf_now), .uf_pulse(tmr_b_uf)
  );

  always_comb begin
    case (bus_addr)
      OFS_A_LO:  bus_rdata = a_cnt[DATA_W-1:0];
      OFS_A_HI:  bus_rdata = a_cnt[CNT_W-1:DATA_W];
      OFS_B_LO:  bus_rdata = b_cnt[DATA_W-1:0];
      OFS_B_HI:  bus_rdata = b_cnt[CNT_W-1:DATA_W];
      OFS_A_CTL: bus_rdata = a_ctl;
      OFS_B_CTL: bus_rdata = b_ctl;
      default:   bus_rdata = '0;
    endcase
  end

  // R9: a gated or plain cascade never moves B without an A underflow
  p_casc_needs_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    b_ctl[CTL_START] && b_ctl[CTL_SRC_HI] && !a_uf_now && !wr |=> $stable(b_cnt));

  // R10: gated cascade ignores A underflows while the pin is low
  p_gate_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    b_ctl[CTL_START] && b_ctl[CTL_SRC_HI] && b_ctl[CTL_SRC_LO] && !pin_level && !wr
      |=> $stable(b_cnt));

  p_b_uf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_uf_now |=> tmr_b_uf);
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, count_pin = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tmr_a_uf, tmr_b_uf;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_pin(count_pin), .tmr_a_uf(tmr_a_uf), .tmr_b_uf(tmr_b_uf)
  );

  // ---------------- cycle model from the requirements ----------------
  logic [15:0] m_lat [2];
  logic [15:0] m_cnt [2];
  logic [7:0]  m_ctl [2];
  logic m_ua, m_ub, m_s1, m_s2, m_s3;

  task automatic m_upd(input int t, input logic tk, input logic wlo, input logic whi,
                       input logic wct, input logic [7:0] d, output logic uf);
    logic [15:0] ln;
    logic run;
    run = m_ctl[t][0];
    ln = m_lat[t];
    if (wlo) ln[7:0] = d;
    if (whi) ln[15:8] = d;
    uf = run && tk && m_cnt[t] == 16'd0 && !wct;
    if (wct) begin
      m_ctl[t] = d & 8'hEF;
      if (d[4] || !d[0]) m_cnt[t] = ln;
    end else if (whi && !run) begin
      m_cnt[t] = ln;
    end else if (run && tk) begin
      if (m_cnt[t] == 16'd0) begin
        m_cnt[t] = ln;
        if (m_ctl[t][3]) m_ctl[t][0] = 1'b0;
      end else m_cnt[t] = m_cnt[t] - 16'd1;
    end
    m_lat[t] = ln;
  endtask

  always @(posedge clk) begin
    logic rise, lvl, wr, ua, ub, tka, tkb;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_lat[i] = 16'hFFFF; m_cnt[i] = 16'hFFFF; m_ctl[i] = 8'h00;
      end
      m_ua = 0; m_ub = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      rise = m_s2 & ~m_s3;
      lvl = m_s2;
      wr = bus_sel & bus_we;
      tka = m_ctl[0][5] ? rise : 1'b1;
      m_upd(0, tka, wr && bus_addr == 4'h4, wr && bus_addr == 4'h5,
            wr && bus_addr == 4'hE, bus_wdata, ua);
      case (m_ctl[1][6:5])
        2'b00: tkb = 1'b1;
        2'b01: tkb = rise;
        2'b10: tkb = ua;
        default: tkb = ua & lvl;
      endcase
      m_upd(1, tkb, wr && bus_addr == 4'h6, wr && bus_addr == 4'h7,
            wr && bus_addr == 4'hF, bus_wdata, ub);
      m_ua = ua; m_ub = ub;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = count_pin;
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h4: return m_cnt[0][7:0];
      4'h5: return m_cnt[0][15:8];
      4'h6: return m_cnt[1][7:0];
      4'h7: return m_cnt[1][15:8];
      4'hE: return m_ctl[0];
      4'hF: return m_ctl[1];
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [3:0] a,
                      input logic [7:0] d, input logic p, input string tag);
    @(negedge clk);
    chk({15'd0, tmr_a_uf}, {15'd0, m_ua}, tag);
    chk({15'd0, tmr_b_uf}, {15'd0, m_ub}, tag);
    if (bus_sel && !bus_we) chk({8'd0, bus_rdata}, {8'd0, m_read(bus_addr)}, tag);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; count_pin = p;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(1, 1, a, d, count_pin, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 8'h00, count_pin, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag, output logic [7:0] v);
    step(1, 0, a, 8'h00, count_pin, tag);
    #1 v = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int first, second, cyc;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    rd(4'h4, "R1", v); chk(v, 8'hFF, "R1");
    rd(4'h5, "R1", v); chk(v, 8'hFF, "R1");
    rd(4'h7, "R1", v); chk(v, 8'hFF, "R1");
    rd(4'hE, "R1", v); chk(v, 8'h00, "R1");
    rd(4'hF, "R1", v); chk(v, 8'h00, "R1");
    // R2: undecoded offset reads zero
    rd(4'h2, "R2", v); chk(v, 8'h00, "R2");

    // R3: low write while stopped leaves counter; high write loads
    wr(4'h4, 8'h10, "R3");
    rd(4'h4, "R3", v); chk(v, 8'hFF, "R3");
    wr(4'h5, 8'h00, "R3");
    rd(4'h4, "R3", v); chk(v, 8'h10, "R3");
    rd(4'h5, "R2", v); chk(v, 8'h00, "R2");
    // R12: stopped counter holds
    idle(10, "R12");
    rd(4'h4, "R12", v); chk(v, 8'h10, "R12");

    // R4: force load and bit 4 reads 0
    wr(4'h4, 8'h05, "R4");
    wr(4'hE, 8'h10, "R4");
    rd(4'h4, "R4", v); chk(v, 8'h05, "R4");
    rd(4'hE, "R4", v); chk(v, 8'h00, "R4");
    // R5: control write with start clear reloads
    wr(4'h4, 8'h07, "R5");
    wr(4'hE, 8'h00, "R5");
    rd(4'h4, "R5", v); chk(v, 8'h07, "R5");

    // R6: period of L+1 with latch 3, continuous
    wr(4'h4, 8'h03, "R6");
    wr(4'h5, 8'h00, "R6");
    wr(4'hE, 8'h01, "R6");
    first = -1; second = -1; cyc = 0;
    while (second < 0 && cyc < 40) begin
      step(0, 0, 4'h0, 8'h00, count_pin, "R6");
      if (tmr_a_uf) begin
        if (first < 0) first = cyc; else second = cyc;
      end
      cyc++;
    end
    chk(16'(second - first), 16'd4, "R6");

    // R7: one-shot clears start bit
    wr(4'hE, 8'h19, "R7");
    idle(12, "R7");
    rd(4'hE, "R7", v); chk(v, 8'h08, "R7");
    rd(4'h4, "R7", v); chk(v, 8'h03, "R7");

    // R8: timer A counts synchronised pin rises
    wr(4'h4, 8'h0A, "R8");
    wr(4'hE, 8'h31, "R8");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) step(0, 0, 4'h0, 8'h00, 1'b1, "R8");
      for (int i = 0; i < 4; i++) step(0, 0, 4'h0, 8'h00, 1'b0, "R8");
    end
    rd(4'h4, "R8", v); chk(v, 8'h07, "R8");

    // R11: timer B counts pin rises with source 01, clocks with 00
    wr(4'h6, 8'h0A, "R11");
    wr(4'h7, 8'h00, "R11");
    wr(4'hF, 8'h31, "R11");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) step(0, 0, 4'h0, 8'h00, 1'b1, "R11");
      for (int i = 0; i < 4; i++) step(0, 0, 4'h0, 8'h00, 1'b0, "R11");
    end
    rd(4'h6, "R11", v); chk(v, 8'h07, "R11");
    wr(4'hF, 8'h11, "R11");
    idle(5, "R11");

    // R9: B counts A underflows; A latch 2 continuous
    wr(4'h4, 8'h02, "R9");
    wr(4'hE, 8'h11, "R9");
    wr(4'h6, 8'h04, "R9");
    wr(4'hF, 8'h51, "R9");
    idle(40, "R9");
    rd(4'h6, "R9", v); chk(v, m_read(4'h6), "R9");

    // R10: gated cascade, pin low then high
    wr(4'h6, 8'h05, "R10");
    wr(4'hF, 8'h71, "R10");
    for (int i = 0; i < 30; i++) step(0, 0, 4'h0, 8'h00, 1'b0, "R10");
    rd(4'h6, "R10", v); chk(v, 8'h05, "R10");
    for (int i = 0; i < 40; i++) step(0, 0, 4'h0, 8'h00, 1'b1, "R10");
    rd(4'h6, "R10", v); chk(v, m_read(4'h6), "R10");
    for (int i = 0; i < 20; i++) step(0, 0, 4'h0, 8'h00, 1'b0, "R10");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic p;
      r = int'($urandom_range(99));
      p = ($urandom_range(3) == 0) ? ~count_pin : count_pin;
      if (r < 70) step(0, 0, 4'h0, 8'h00, p, "R6");
      else if (r < 80) begin
        logic [3:0] ra;
        case ($urandom_range(6))
          0: ra = 4'h4; 1: ra = 4'h5; 2: ra = 4'h6; 3: ra = 4'h7;
          4: ra = 4'hE; 5: ra = 4'hF; default: ra = 4'h9;
        endcase
        step(1, 0, ra, 8'h00, p, "R2");
      end else begin
        case ($urandom_range(5))
          0: step(1, 1, 4'h4, 8'($urandom_range(12)), p, "R2");
          1: step(1, 1, 4'h5, ($urandom_range(7) == 0) ? 8'h01 : 8'h00, p, "R3");
          2: step(1, 1, 4'h6, 8'($urandom_range(12)), p, "R2");
          3: step(1, 1, 4'h7, ($urandom_range(7) == 0) ? 8'h01 : 8'h00, p, "R3");
          4: step(1, 1, 4'hE, 8'($urandom) & 8'h7F, p, "R7");
          default: step(1, 1, 4'hF, 8'($urandom) & 8'h7F, p, "R10");
        endcase
      end
    end
    idle(4, "R6");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule